// File: doc/BRIEF.md
# Dynamic pixel-pair hit formatter

This block turns triggered pixel hits into fixed 24-bit words for an output FIFO. Hits arrive one per handshake as (column, row, ToT) beats, sorted by column and then by row. An event is closed by a separate end-of-event beat that carries no hit. When a hit is followed in the stream by the hit one row above it in the same column, the two are merged into one record with two ToT fields. A hit with no such partner becomes a record whose second ToT holds the all-ones "no hit" code.

The first beat of every event makes the block write a header word. The header holds the current value of a 13-bit bunch-crossing counter. That counter advances on every clock and is cleared by a reset strobe. The end-of-event beat makes the block write a trailer word. The trailer holds the number of records written for the event and a flag that is set if records were dropped. Records beyond a parameterised per-event cap are dropped. When the downstream FIFO reports full, the block writes nothing and loses nothing: it stalls and waits.

Top module: `pixel_pair_formatter`

## Requirements
- R1: A data record is {column[23:17], row of the lower hit[16:8], ToT of the lower hit[7:4], second ToT[3:0]}. The column field of a record always lies in 1..N_COLS.
- R2: A hit immediately followed in the input by a hit in the same column and the next row up yields exactly one record, with the follower's ToT in bits [3:0]. After a pair is formed, the next hit starts a new candidate. So rows r, r+1, r+2 give one pair and one lone record.
- R3: A hit whose follower is in another column, is in a non-adjacent row, or is the end-of-event beat yields a record with bits [3:0] = 4'hF. Input hits never carry ToT 4'hF.
- R4: The first beat of an event causes a header {7'h7F in [23:17], zeros in [16:13], bunch-crossing ID in [12:0]}. The header is written before any record of that event.
- R5: The end-of-event beat causes a trailer {7'h7E in [23:17], truncation flag in [16], record count in [15:0]}. The trailer is written after the event's last record.
- R6: The bunch-crossing counter is cleared by the clock edge that samples bcr high. It then rises by one every clock and wraps modulo 8192.
- R7: At most MAX_RECORDS records are written per event. Further records are discarded. The trailer then reports flag 1 and count MAX_RECORDS. An event with exactly MAX_RECORDS records reports flag 0. The next event starts with count 0 and flag 0.
- R8: While fifo_full is high, out_wr stays low. Stalling never removes, duplicates or reorders words.
- R9: After reset with no input offered, out_wr and in_ready are low and no event is open.
- R10: An event made of only the end-of-event beat produces a header immediately followed by a trailer with count 0 and flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bcr | input | 1 | Clears the bunch-crossing counter |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat taken at this clock edge |
| in_eoe | input | 1 | Beat is an end-of-event marker, not a hit |
| in_col | input | 7 | Hit column, 1..N_COLS |
| in_row | input | 9 | Hit row |
| in_tot | input | 4 | Hit ToT, 0..14 |
| fifo_full | input | 1 | Downstream FIFO cannot take a word this cycle |
| out_wr | output | 1 | Write strobe for the FIFO |
| out_word | output | 24 | Header, record or trailer word |

## Verification
The checker takes three things about the inputs for granted. First, every hit beat has a column in 1..N_COLS and a ToT other than 4'hF. Second, a stalled beat stays valid and unchanged until it is taken. Third, fifo_full means that no write may be made in that same cycle. Hits are also assumed to arrive sorted by column and then by row, which is what makes the single lookahead register sufficient. The stimulus produces only sorted, in-range hits with ToT values below 15. It holds each beat steady until the handshake completes. It changes fifo_full only just after a clock edge, so the write strobe it sees is already settled by the time it samples.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
    localparam int COL_W       = 7;
    localparam int ROW_W       = 9;
    localparam int TOT_W       = 4;
    localparam int BCID_W      = 13;
    localparam int WORD_W      = COL_W + ROW_W + 2 * TOT_W;
    localparam int CNT_FIELD_W = WORD_W - COL_W - 1;
    localparam int HDR_PAD_W   = WORD_W - COL_W - BCID_W;

    localparam logic [COL_W-1:0] TAG_HDR  = '1;
    localparam logic [COL_W-1:0] TAG_TRL  = {{(COL_W-1){1'b1}}, 1'b0};
    localparam logic [TOT_W-1:0] TOT_NONE = '1;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [TOT_W-1:0] tot;
    } hit_t;

    typedef enum logic {ST_IDLE, ST_OPEN} fmt_state_e;

    typedef struct packed {
        fmt_state_e state;
        logic       pend_v;
        hit_t       pend;
        logic       trunc;
    } fmt_regs_t;

    function automatic logic [WORD_W-1:0] pack_data(hit_t h, logic [TOT_W-1:0] t2);
        return {h.col, h.row, h.tot, t2};
    endfunction

    function automatic logic [WORD_W-1:0] pack_header(logic [BCID_W-1:0] b);
        return {TAG_HDR, {HDR_PAD_W{1'b0}}, b};
    endfunction

    function automatic logic [WORD_W-1:0] pack_trailer(logic f, logic [CNT_FIELD_W-1:0] n);
        return {TAG_TRL, f, n};
    endfunction
endpackage

// File: rtl/pixfmt_bxcounter.sv
module pixfmt_bxcounter #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bcr,
    output logic [W-1:0] bcid
);
    logic [W-1:0] bcid_d, bcid_q;

    always_comb begin
        bcid_d = bcr ? '0 : bcid_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bcid_q <= '0;
        else        bcid_q <= bcid_d;
    end

    assign bcid = bcid_q;
endmodule

// File: rtl/pixfmt_reccount.sv
module pixfmt_reccount #(
    parameter int MAX   = 32,
    localparam int CNT_W = $clog2(MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_cap
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                      cnt_d = '0;
        else if (inc && cnt_q != CAP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count  = cnt_q;
    assign at_cap = (cnt_q == CAP);
endmodule

// File: rtl/pixfmt_neighbor.sv
module pixfmt_neighbor
    import pixfmt_pkg::*;
(
    input  logic             pend_v,
    input  hit_t             pend,
    input  logic             cand_eoe,
    input  logic [COL_W-1:0] cand_col,
    input  logic [ROW_W-1:0] cand_row,
    output logic             pairable
);
    logic [ROW_W:0] row_above;

    always_comb begin
        row_above = {1'b0, pend.row} + 1'b1;
        pairable  = pend_v && !cand_eoe
                    && (cand_col == pend.col)
                    && ({1'b0, cand_row} == row_above);
    end
endmodule

// File: rtl/pixel_pair_formatter.sv
module pixel_pair_formatter
    import pixfmt_pkg::*;
#(
    parameter int N_COLS      = 80,
    parameter int MAX_RECORDS = 32,
    localparam int CNT_W      = $clog2(MAX_RECORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bcr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_eoe,
    input  logic [COL_W-1:0]  in_col,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [TOT_W-1:0]  in_tot,
    input  logic              fifo_full,
    output logic              out_wr,
    output logic [WORD_W-1:0] out_word
);
    fmt_regs_t          r_d, r_q;
    hit_t               beat;
    logic               pairable;
    logic [BCID_W-1:0]  bcid;
    logic [CNT_W-1:0]   rec_cnt;
    logic               at_cap;
    logic               cnt_clr, cnt_inc;
    logic [TOT_W-1:0]   tot2;

    assign beat = '{col: in_col, row: in_row, tot: in_tot};

    pixfmt_bxcounter #(.W(BCID_W)) u_bx (
        .clk(clk), .rst_n(rst_n), .bcr(bcr), .bcid(bcid)
    );

    pixfmt_reccount #(.MAX(MAX_RECORDS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .count(rec_cnt), .at_cap(at_cap)
    );

    pixfmt_neighbor u_nb (
        .pend_v(r_q.pend_v), .pend(r_q.pend), .cand_eoe(in_eoe),
        .cand_col(in_col), .cand_row(in_row), .pairable(pairable)
    );

    always_comb begin
        r_d      = r_q;
        in_ready = 1'b0;
        out_wr   = 1'b0;
        out_word = '0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        tot2     = pairable ? in_tot : TOT_NONE;

        case (r_q.state)
            ST_IDLE: begin
                if (in_valid && !fifo_full) begin
                    out_wr    = 1'b1;
                    out_word  = pack_header(bcid);
                    cnt_clr   = 1'b1;
                    r_d.trunc = 1'b0;
                    r_d.state = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (in_valid) begin
                    if (!r_q.pend_v) begin
                        if (in_eoe) begin
                            if (!fifo_full) begin
                                out_wr    = 1'b1;
                                out_word  = pack_trailer(r_q.trunc, CNT_FIELD_W'(rec_cnt));
                                in_ready  = 1'b1;
                                r_d.state = ST_IDLE;
                            end
                        end else begin
                            in_ready   = 1'b1;
                            r_d.pend_v = 1'b1;
                            r_d.pend   = beat;
                        end
                    end else if (at_cap || !fifo_full) begin
                        if (at_cap) begin
                            r_d.trunc = 1'b1;
                        end else begin
                            out_wr   = 1'b1;
                            out_word = pack_data(r_q.pend, tot2);
                            cnt_inc  = 1'b1;
                        end
                        if (pairable) begin
                            in_ready   = 1'b1;
                            r_d.pend_v = 1'b0;
                        end else if (!in_eoe) begin
                            in_ready = 1'b1;
                            r_d.pend = beat;
                        end else begin
                            r_d.pend_v = 1'b0;
                        end
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.pend_v <= 1'b0;
            r_q.pend   <= '0;
            r_q.trunc  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/pixfmt_chk.sv
module pixfmt_chk
    import pixfmt_pkg::*;
#(
    parameter int N_COLS      = 80,
    parameter int MAX_RECORDS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_eoe,
    input logic [COL_W-1:0]  in_col,
    input logic [ROW_W-1:0]  in_row,
    input logic [TOT_W-1:0]  in_tot,
    input logic              fifo_full,
    input logic              out_wr,
    input logic [WORD_W-1:0] out_word
);
    localparam logic [COL_W-1:0]     COL_MAX = COL_W'(N_COLS);
    localparam logic [CNT_FIELD_W:0] CAP     = (CNT_FIELD_W + 1)'(MAX_RECORDS);

    logic [COL_W-1:0]     tag;
    logic                 is_hdr, is_trl, is_dat;
    logic                 open_q;
    logic [CNT_FIELD_W:0] dcnt_q;

    assign tag    = out_word[WORD_W-1 -: COL_W];
    assign is_hdr = (tag == TAG_HDR);
    assign is_trl = (tag == TAG_TRL);
    assign is_dat = !is_hdr && !is_trl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            dcnt_q <= '0;
        end else if (out_wr) begin
            if (is_hdr) begin
                open_q <= 1'b1;
                dcnt_q <= '0;
            end else if (is_trl) begin
                open_q <= 1'b0;
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    // Input-side assumptions
    assert_hit_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_eoe) |-> (in_col != '0 && in_col <= COL_MAX && in_tot != TOT_NONE));
    assert_src_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> (in_valid && $stable({in_eoe, in_col, in_row, in_tot})));

    // Output behaviour
    assert_no_write_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !out_wr);
    assert_header_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && is_hdr) |-> !open_q);
    assert_record_inside_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && is_dat) |-> (open_q && tag != '0 && tag <= COL_MAX));
    assert_record_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && is_dat) |-> (dcnt_q < CAP));
    assert_trailer_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && is_trl) |-> (open_q && out_word[CNT_FIELD_W-1:0] == dcnt_q[CNT_FIELD_W-1:0]));
    assert_trunc_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && is_trl && out_word[CNT_FIELD_W]) |-> (dcnt_q == CAP));
endmodule

bind pixel_pair_formatter pixfmt_chk #(
    .N_COLS(N_COLS),
    .MAX_RECORDS(MAX_RECORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_eoe(in_eoe),
    .in_col(in_col), .in_row(in_row), .in_tot(in_tot),
    .fifo_full(fifo_full), .out_wr(out_wr), .out_word(out_word)
);

// File: tb/pixel_pair_formatter_test.sv
module pixel_pair_formatter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bcr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_eoe = 1'b0;
    logic [6:0]  in_col = '0;
    logic [8:0]  in_row = '0;
    logic [3:0]  in_tot = '0;
    logic        fifo_full = 1'b0;
    logic        out_wr;
    logic [23:0] out_word;

    localparam int CAP = 32;

    always #10 clk = ~clk;

    pixel_pair_formatter #(.N_COLS(80), .MAX_RECORDS(CAP)) uut (
        .clk(clk), .rst_n(rst_n), .bcr(bcr),
        .in_valid(in_valid), .in_ready(in_ready), .in_eoe(in_eoe),
        .in_col(in_col), .in_row(in_row), .in_tot(in_tot),
        .fifo_full(fifo_full), .out_wr(out_wr), .out_word(out_word)
    );

    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;
    int bcr_cyc = 0;
    int full_wr_err = 0;
    logic [23:0] got_w[$];
    int          got_c[$];
    logic [23:0] exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_wr) begin
            got_w.push_back(out_word);
            got_c.push_back(cyc);
            if (fifo_full) full_wr_err++;
        end
    end

    function automatic logic [23:0] dw(int c, int r, int t1, int t2);
        return {7'(c), 9'(r), 4'(t1), 4'(t2)};
    endfunction

    function automatic logic [23:0] tw(bit f, int n);
        return {7'h7E, f, 16'(n)};
    endfunction

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(bit eoe, int c, int r, int t);
        bit ok;
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_eoe   = eoe;
        in_col   = 7'(c);
        in_row   = 9'(r);
        in_tot   = 4'(t);
        do begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk);
        end while (!ok);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic expect_event(string req);
        int waited = 0;
        logic [23:0] e;
        while (got_w.size() < exp_q.size() && waited < 2000) begin
            @(posedge clk);
            waited++;
        end
        repeat (4) @(posedge clk);
        chk({req, " word count"}, 24'(got_w.size()), 24'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_w.size(); i++) begin
            if (i == 0) e = {7'h7F, 4'h0, 13'(got_c[0] - bcr_cyc)};
            else        e = exp_q[i];
            chk(req, got_w[i], e);
        end
        got_w.delete();
        got_c.delete();
        exp_q.delete();
    endtask

    task automatic pulse_bcr();
        @(posedge clk);
        #1 bcr = 1'b1;
        @(posedge clk);
        #1 bcr = 1'b0;
        bcr_cyc = cyc;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 out_wr after reset", 24'(out_wr), 24'd0);
        chk("R9 in_ready after reset", 24'(in_ready), 24'd0);
        repeat (3) @(posedge clk);
        chk("R9 no word while idle", 24'(got_w.size()), 24'd0);
    endtask

    task automatic t_lone();
        exp_q.push_back('0);
        push(0, 12, 200, 9);
        push(1, 0, 0, 0);
        exp_q.push_back(dw(12, 200, 9, 15));
        exp_q.push_back(tw(0, 1));
        expect_event("R3 R1 R4 R5 lone hit");
    endtask

    task automatic t_pair();
        exp_q.push_back('0);
        push(0, 5, 10, 3);
        push(0, 5, 11, 7);
        push(1, 0, 0, 0);
        exp_q.push_back(dw(5, 10, 3, 7));
        exp_q.push_back(tw(0, 1));
        expect_event("R2 pair");
    endtask

    task automatic load_mixed();
        exp_q.push_back('0);
        exp_q.push_back(dw(2, 100, 1, 2));
        exp_q.push_back(dw(2, 102, 3, 15));
        exp_q.push_back(dw(4, 102, 9, 4));
        exp_q.push_back(dw(5, 1, 0, 15));
        exp_q.push_back(dw(6, 50, 1, 15));
        exp_q.push_back(dw(7, 51, 2, 15));
        exp_q.push_back(dw(8, 4, 5, 15));
        exp_q.push_back(dw(8, 6, 6, 15));
        exp_q.push_back(tw(0, 8));
    endtask

    task automatic send_mixed();
        push(0, 2, 100, 1);
        push(0, 2, 101, 2);
        push(0, 2, 102, 3);
        push(0, 4, 102, 9);
        push(0, 4, 103, 4);
        push(0, 5, 1, 0);
        push(0, 6, 50, 1);
        push(0, 7, 51, 2);
        push(0, 8, 4, 5);
        push(0, 8, 6, 6);
        push(1, 0, 0, 0);
    endtask

    task automatic t_mixed();
        load_mixed();
        send_mixed();
        expect_event("R2 R3 mixed stream");
    endtask

    task automatic t_empty();
        exp_q.push_back('0);
        push(1, 0, 0, 0);
        exp_q.push_back(tw(0, 0));
        expect_event("R10 empty event");
    endtask

    task automatic t_trunc(int n);
        int kept;
        kept = (n > CAP) ? CAP : n;
        exp_q.push_back('0);
        for (int k = 0; k < n; k++) begin
            push(0, 1, 2 * k + 1, k % 15);
            if (k < CAP) exp_q.push_back(dw(1, 2 * k + 1, k % 15, 15));
        end
        push(1, 0, 0, 0);
        exp_q.push_back(tw(n > CAP, kept));
        expect_event("R7 truncation");
    endtask

    task automatic t_backpressure();
        full_wr_err = 0;
        load_mixed();
        fork
            send_mixed();
            begin
                for (int k = 0; k < 80; k++) begin
                    @(posedge clk);
                    #2 fifo_full = (k % 3 != 0) || (k >= 20 && k < 30);
                end
                @(posedge clk);
                #2 fifo_full = 1'b0;
            end
        join
        expect_event("R8 stalled stream");
        chk("R8 no write while full", 24'(full_wr_err), 24'd0);
    endtask

    task automatic t_bcid_wrap();
        pulse_bcr();
        repeat (8200) @(posedge clk);
        exp_q.push_back('0);
        push(1, 0, 0, 0);
        exp_q.push_back(tw(0, 0));
        chk("R6 wrap window", 24'((cyc - bcr_cyc) > 8192), 24'd1);
        expect_event("R6 bunch-crossing wrap");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        pulse_bcr();
        t_lone();
        t_pair();
        t_mixed();
        t_empty();
        pulse_bcr();
        repeat (37) @(posedge clk);
        t_empty();
        t_trunc(CAP);
        t_trunc(CAP + 8);
        t_empty();
        t_backpressure();
        t_bcid_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule